// File: doc/BRIEF.md
# Coherent Multi-Bit Word Synchronizer

This block moves a multi-bit word, for example an address together with its data, from a source that runs on its own clock into a receiving clock domain. It ensures that receiving logic never sees a word that mixes old and new bits. The source places the word on its bus, raises a request, and keeps both steady until an acknowledge comes back. Only the request line crosses the boundary through a chain of synchronizing flops. The data bits are never synchronized one by one.

When the receiving side sees the synchronized request, it samples the whole word in a single cycle into a separate holding bank of registers. In that same cycle it raises a one-cycle valid strobe. Downstream logic reads only that holding bank. The acknowledge is raised in the receiving domain and passes back through its own synchronizer chain into the source clock domain. It stays high until the receiver sees the request withdrawn, which completes a four-phase handshake.

Top module: `word_xfer_sync`

## Requirements
- R1: While either reset is asserted and after it is released, `out_word` is all zeros, and `out_valid` and `src_ack` are 0 until the first request.
- R2: A word is captured only after the request has passed through the SYNC_STAGES-flop chain. `out_valid` never rises earlier than SYNC_STAGES receiving-clock cycles after `src_req` is seen high, and `src_req` is high in the cycle before the strobe.
- R3: Each value released on `out_word` equals, bit for bit, the word the source presented with the corresponding request. Transfers are delivered in order.
- R4: `out_valid` is high for exactly one receiving-clock cycle per transfer. It rises in the same cycle in which `out_word` takes its new value.
- R5: `out_word` changes only in a cycle in which `out_valid` is high. Between transfers it holds the last delivered word.
- R6: The receiving-side acknowledge rises in the same cycle as the valid strobe. `src_ack` reaches the source only after the word has been delivered.
- R7: A request that stays high after the acknowledge produces no second capture. A new capture is possible only after the acknowledge has dropped in response to the request going low.
- R8: With `src_req` low, changes on `src_word` have no effect on `out_word` or `out_valid`.
- R9: After `src_req` is withdrawn, `src_ack` falls no sooner than SYNC_STAGES source-clock cycles later. This returns the handshake to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock, used only by the acknowledge synchronizer |
| src_rst_n | input | 1 | Active-low asynchronous reset for the source-domain flops |
| src_req | input | 1 | Request from the source, asynchronous to `clk` |
| src_word | input | WIDTH | Word offered by the source, held steady from request to acknowledge |
| src_ack | output | 1 | Acknowledge synchronized into the source domain |
| clk | input | 1 | Receiving-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for the receiving-domain flops |
| out_word | output | WIDTH | Holding bank contents, the only word downstream logic reads |
| out_valid | output | 1 | One-cycle strobe marking a fresh word on `out_word` |

## Verification
Transfers are made with all-zero, all-one, alternating and walking-one words. These patterns separate a correct whole-word capture from a lane that is loaded from the wrong slice or left behind. Two identical words are sent back to back, which shows that a strobe fires even when the value does not change. A request is held high long after its acknowledge while the bus is deliberately corrupted, which separates one capture per handshake from repeated sampling. Bus activity with no request shows that an idle source cannot disturb the held word.

// File: rtl/wxs_pkg.sv
package wxs_pkg;
   typedef enum logic [0:0] {
      RX_IDLE = 1'b0,
      RX_HELD = 1'b1
   } rx_state_e;

   function automatic int lane_count(input int width, input int lane_w);
      return (width + lane_w - 1) / lane_w;
   endfunction
endpackage

// File: rtl/wxs_bit_sync.sv
module wxs_bit_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wxs_rx_ctrl.sv
module wxs_rx_ctrl
   import wxs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_sync,
   output logic capture,
   output logic ack_dst,
   output logic valid
);
   rx_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      capture = 1'b0;
      unique case (state_q)
         RX_IDLE: begin
            if (req_sync) begin
               capture = 1'b1;
               state_d = RX_HELD;
            end
         end
         RX_HELD: begin
            if (!req_sync) state_d = RX_IDLE;
         end
         default: state_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         valid   <= 1'b0;
      end else begin
         state_q <= state_d;
         valid   <= capture;
      end
   end

   assign ack_dst = (state_q == RX_HELD);
endmodule

// File: rtl/wxs_hold_bank.sv
module wxs_hold_bank
   import wxs_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int LANE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int NUM_LANES = lane_count(WIDTH, LANE_W);

   logic [LANE_W-1:0] lane_q [NUM_LANES];

   genvar l;
   generate
      for (l = 0; l < NUM_LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    lane_q[l] <= '0;
            else if (load) lane_q[l] <= d[l*LANE_W +: LANE_W];
         end
         assign q[l*LANE_W +: LANE_W] = lane_q[l];
      end
   endgenerate
endmodule

// File: rtl/word_xfer_sync.sv
module word_xfer_sync #(
   parameter int WIDTH       = 16,
   parameter int LANE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             src_clk,
   input  logic             src_rst_n,
   input  logic             src_req,
   input  logic [WIDTH-1:0] src_word,
   output logic             src_ack,
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] out_word,
   output logic             out_valid
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("word_xfer_sync: SYNC_STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("word_xfer_sync: WIDTH must be positive");
      end
      if (LANE_W < 1 || (WIDTH % LANE_W) != 0) begin : g_bad_lane
         $error("word_xfer_sync: LANE_W must divide WIDTH");
      end
   endgenerate

   logic req_dst;
   logic capture;
   logic ack_dst;

   wxs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_req),
      .q     (req_dst)
   );

   wxs_rx_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_sync (req_dst),
      .capture  (capture),
      .ack_dst  (ack_dst),
      .valid    (out_valid)
   );

   wxs_hold_bank #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (capture),
      .d     (src_word),
      .q     (out_word)
   );

   wxs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (src_clk),
      .rst_n (src_rst_n),
      .d     (ack_dst),
      .q     (src_ack)
   );
endmodule

// File: rtl/word_xfer_sync_chk.sv
module word_xfer_sync_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             src_req,
   input logic             ack_dst,
   input logic [WIDTH-1:0] out_word,
   input logic             out_valid
);
   // R2
   r2_req_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(src_req));

   // R4
   r4_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R5
   r5_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_word));

   // R6
   r6_ack_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_dst) |-> out_valid);

   // R7
   r7_no_recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$past(ack_dst));
endmodule

bind word_xfer_sync word_xfer_sync_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_req   (src_req),
   .ack_dst   (ack_dst),
   .out_word  (out_word),
   .out_valid (out_valid)
);

// File: tb/sim_word_xfer_sync.sv
`timescale 1ns/1ps
module sim_word_xfer_sync;
   localparam int W  = 16;
   localparam int LW = 8;
   localparam int ST = 2;

   logic         clk = 1'b0;
   logic         src_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_rst_n = 1'b0;
   logic         src_req = 1'b0;
   logic [W-1:0] src_word = '0;
   logic         src_ack;
   logic [W-1:0] out_word;
   logic         out_valid;

   always #2.5 clk = ~clk;
   always #3.5 src_clk = ~src_clk;

   word_xfer_sync #(.WIDTH(W), .LANE_W(LW), .SYNC_STAGES(ST)) u0 (
      .src_clk   (src_clk),
      .src_rst_n (src_rst_n),
      .src_req   (src_req),
      .src_word  (src_word),
      .src_ack   (src_ack),
      .clk       (clk),
      .rst_n     (rst_n),
      .out_word  (out_word),
      .out_valid (out_valid)
   );

   int           checks = 0;
   int           fails  = 0;
   int           pulses = 0;
   int           since_req = 0;
   bit           prev_valid = 0;
   bit           r4_bad = 0;
   bit           r5_bad = 0;
   logic [W-1:0] last_word = '0;
   logic [W-1:0] exp_q [$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as words are released
   always @(negedge clk) begin
      if (rst_n) begin
         if (src_req) since_req++;
         else         since_req = 0;
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected strobe", out_word, 0);
            end else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(out_word == e, "R3 word", out_word, e);
            end
            chk(since_req >= ST, "R2 latency", since_req, ST);
            if (prev_valid) r4_bad = 1;
            pulses++;
            last_word = out_word;
         end else if (out_word !== last_word) begin
            r5_bad = 1;
         end
         prev_valid = out_valid;
      end
   end

   // Driver: one four-phase transfer, request held 'extra' cycles past ack
   task automatic xfer(input logic [W-1:0] word, input int extra);
      int p0;
      int n;
      p0 = pulses;
      @(posedge src_clk); #1;
      src_word = word;
      src_req  = 1'b1;
      exp_q.push_back(word);
      do @(posedge src_clk); while (!src_ack);
      #1;
      chk(pulses == p0 + 1, "R6 ack after strobe", pulses, p0 + 1);
      src_word = ~word;
      repeat (extra) @(posedge src_clk);
      #1;
      chk(pulses == p0 + 1, "R7 held request single capture", pulses, p0 + 1);
      src_req = 1'b0;
      n = 0;
      do begin @(posedge src_clk); n++; end while (src_ack);
      chk(n >= ST, "R9 ack release delay", n, ST);
      @(negedge clk);
      chk(out_word == word, "R5 word held after handshake", out_word, word);
   endtask

   initial begin : watchdog
      #200000ns;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      src_rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1
      chk(out_word == '0, "R1 reset word", out_word, 0);
      chk(out_valid == 1'b0, "R1 reset strobe", out_valid, 0);
      chk(src_ack == 1'b0, "R1 reset ack", src_ack, 0);

      xfer(16'h0000, 0);
      xfer(16'hFFFF, 0);
      xfer(16'hA55A, 3);
      xfer(16'hA55A, 0);
      for (int i = 0; i < W; i += 5) xfer(W'(1) << i, i % 3);
      xfer(16'h00FF, 12);

      // R8: bus activity with no request
      begin
         int p0;
         logic [W-1:0] held;
         p0 = pulses;
         held = out_word;
         for (int k = 0; k < 6; k++) begin
            @(posedge src_clk); #1;
            src_word = W'(16'h1234 * (k + 3));
         end
         repeat (10) @(negedge clk);
         chk(pulses == p0, "R8 idle bus no strobe", pulses, p0);
         chk(out_word == held, "R8 idle bus word kept", out_word, held);
      end

      xfer(16'h3C96, 1);
      repeat (5) @(negedge clk);

      chk(!r4_bad, "R4 strobe one cycle", r4_bad, 0);
      chk(!r5_bad, "R5 word changes only with strobe", r5_bad, 0);
      chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule